// File: doc/BRIEF.md
# Hardware loop setup register bank

This block keeps the state for zero-overhead loops in a small processor core. Each loop slot holds three 32-bit values: the address of the first instruction in the loop body, the address of the last one, and the number of iterations still to run. A decoded loop-setup operation arrives with the current program counter, the register operand rs1 and two immediates. The block works out the address and count values from these, decodes which fields to write, and updates the slot that the operation names.

A separate loop controller sends a decrement request for the slot it is running. A stall input holds the decrement back. All slots' start, end and counter values are driven out in parallel so that controller can compare them. The decode outputs are combinational from the operation inputs: the per-field write enables, an rs1-used flag for hazard logic, and an illegal-operation flag. The decode core can use them in the same cycle.

Top module: `hwloop_bank`

## Requirements
- R1: After an active-low reset, every start, end and counter field of every slot reads zero.
- R2: Operation code 3'b000 asserts write enable 3'b001 (bit 0 = start) and loads the selected slot's start with pc + imm_i. The other fields are unchanged.
- R3: Operation code 3'b001 asserts write enable 3'b010 (bit 1 = end) and loads the selected slot's end with pc + imm_i.
- R4: Operation code 3'b010 loads the counter with rs1 and raises rs1_used. Code 3'b011 loads the counter with imm_i and leaves rs1_used low. Both assert write enable 3'b100 (bit 2 = counter).
- R5: Operation code 3'b100 asserts write enable 3'b111, raises rs1_used, and loads start = pc + 4, end = pc + imm_i and counter = rs1.
- R6: Operation code 3'b101 asserts write enable 3'b111 and loads start = pc + 4, end = pc + (imm_z shifted left by one, bit 0 zero) and counter = imm_i.
- R7: Codes 3'b110 and 3'b111 raise illegal and assert no write enable, and no field changes. With op_valid low, no write enable, illegal or rs1_used is asserted and no field changes.
- R8: Only the slot whose index equals slot_sel is written. A slot_sel at or above the slot count writes no slot.
- R9: A decrement request with stall low lowers the counter of slot dec_slot by one on the next edge. A counter already at zero stays at zero.
- R10: While stall is high, a decrement request changes no counter.
- R11: A counter write to a slot in the same cycle as a decrement of that slot loads the written value. A decrement of a different slot in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | A loop-setup operation is present |
| funct3_i | input | 3 | Operation code |
| slot_sel_i | input | IDW | Slot written by the operation |
| pc_i | input | XLEN | Program counter of the operation |
| rs1_i | input | XLEN | Forwarded register operand |
| imm_i_i | input | XLEN | Sign-extended I-type immediate |
| imm_z_i | input | XLEN | Z-type immediate, unshifted |
| dec_req_i | input | 1 | Decrement request |
| dec_slot_i | input | IDW | Slot to decrement |
| stall_i | input | 1 | Pipeline stall, holds back the decrement |
| wr_en_o | output | 3 | Field write enables: bit 0 start, bit 1 end, bit 2 counter |
| rs1_used_o | output | 1 | Operation reads rs1 |
| illegal_o | output | 1 | Undefined operation code |
| start_o | output | NSLOT x XLEN | Start address of every slot |
| end_o | output | NSLOT x XLEN | End address of every slot |
| cnt_o | output | NSLOT x XLEN | Iteration counter of every slot |

## Verification
The bench builds the block with its defaults: two slots, 32-bit fields and a 2-bit slot index. A 2-bit index over two slots leaves the codes 2 and 3 unused, so the bench can drive an out-of-range slot select and show that no slot is written. The 32-bit width lets a negative immediate wrap the address sum. With two slots, a counter write to one slot can meet a decrement of the other slot in the same cycle, so both halves of the write-over-decrement rule are exercised.

// File: rtl/hwloop_bank.sv
module hwloop_bank #(
  parameter int NSLOT = 2,
  parameter int XLEN  = 32,
  parameter int IDW   = 2,
  parameter int STEP  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid_i,
  input  logic [2:0]                 funct3_i,
  input  logic [IDW-1:0]             slot_sel_i,
  input  logic [XLEN-1:0]            pc_i,
  input  logic [XLEN-1:0]            rs1_i,
  input  logic [XLEN-1:0]            imm_i_i,
  input  logic [XLEN-1:0]            imm_z_i,
  input  logic                       dec_req_i,
  input  logic [IDW-1:0]             dec_slot_i,
  input  logic                       stall_i,
  output logic [2:0]                 wr_en_o,
  output logic                       rs1_used_o,
  output logic                       illegal_o,
  output logic [NSLOT-1:0][XLEN-1:0] start_o,
  output logic [NSLOT-1:0][XLEN-1:0] end_o,
  output logic [NSLOT-1:0][XLEN-1:0] cnt_o
);

  localparam logic [2:0] OP_START  = 3'b000;
  localparam logic [2:0] OP_END    = 3'b001;
  localparam logic [2:0] OP_CNTREG = 3'b010;
  localparam logic [2:0] OP_CNTIMM = 3'b011;
  localparam logic [2:0] OP_SETREG = 3'b100;
  localparam logic [2:0] OP_SETIMM = 3'b101;
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [2:0]      dec_en;
  logic            full;
  logic [XLEN-1:0] pc_off, start_val, end_val, cnt_val;

  always_comb begin
    dec_en    = 3'b000;
    illegal_o = 1'b0;
    unique case (funct3_i)
      OP_START:             dec_en = 3'b001;
      OP_END:               dec_en = 3'b010;
      OP_CNTREG, OP_CNTIMM: dec_en = 3'b100;
      OP_SETREG, OP_SETIMM: dec_en = 3'b111;
      default:              illegal_o = op_valid_i;
    endcase
  end

  assign wr_en_o    = op_valid_i ? dec_en : 3'b000;
  assign rs1_used_o = op_valid_i && (funct3_i == OP_CNTREG || funct3_i == OP_SETREG);
  assign full       = (funct3_i == OP_SETREG) || (funct3_i == OP_SETIMM);

  assign pc_off    = pc_i + imm_i_i;
  assign start_val = full ? pc_i + STEP_V : pc_off;
  assign end_val   = (funct3_i == OP_SETIMM) ? pc_i + (imm_z_i << 1) : pc_off;
  assign cnt_val   = (funct3_i == OP_CNTREG || funct3_i == OP_SETREG) ? rs1_i : imm_i_i;

  p_illegal_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (wr_en_o == 3'b000));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit, dec_hit;
    assign hit     = (slot_sel_i == IDW'(s));
    assign dec_hit = dec_req_i && !stall_i && (dec_slot_i == IDW'(s)) && (cnt_o[s] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_o[s] <= '0;
        end_o[s]   <= '0;
        cnt_o[s]   <= '0;
      end else begin
        if (hit && wr_en_o[0]) start_o[s] <= start_val;
        if (hit && wr_en_o[1]) end_o[s]   <= end_val;
        if (hit && wr_en_o[2]) cnt_o[s]   <= cnt_val;
        else if (dec_hit)      cnt_o[s]   <= cnt_o[s] - 1'b1;
      end
    end

    p_dec_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_req_i && !stall_i && dec_slot_i == IDW'(s) && !op_valid_i && cnt_o[s] != '0)
        |=> (cnt_o[s] == $past(cnt_o[s]) - 1'b1));

    p_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid_i && cnt_o[s] == '0) |=> (cnt_o[s] == '0));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !op_valid_i) |=> $stable(cnt_o[s]));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && wr_en_o[2] && slot_sel_i == IDW'(s)) |=> (cnt_o[s] == $past(cnt_val)));

    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid_i) |=> ($stable(start_o[s]) && $stable(end_o[s])));
  end

endmodule

// File: tb/hwloop_bank_tb.sv
module hwloop_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 2;
  localparam int XLEN  = 32;
  localparam int IDW   = 2;
  localparam int NV    = 9;

  localparam logic [2:0]  V_F3   [NV] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111, 3'b000};
  localparam logic [1:0]  V_SLOT [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1};
  localparam logic [31:0] V_PC   [NV] = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h200, 32'h300, 32'h310, 32'h314, 32'h400};
  localparam logic [31:0] V_RS1  [NV] = '{32'h99, 32'h98, 32'h11, 32'h97, 32'h25, 32'h96, 32'h95, 32'h94, 32'h93};
  localparam logic [31:0] V_IMMI [NV] = '{32'h40, 32'h80, 32'h5, 32'h7, 32'h3C, 32'h9, 32'h1, 32'h2, 32'hFFFF_FFF0};
  localparam logic [31:0] V_IMMZ [NV] = '{32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h20, 32'h6, 32'h7, 32'h8};
  localparam logic [2:0]  V_WR   [NV] = '{3'b001, 3'b010, 3'b100, 3'b100, 3'b111, 3'b111, 3'b000, 3'b000, 3'b001};

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid_i = 1'b0, dec_req_i = 1'b0, stall_i = 1'b0;
  logic [2:0] funct3_i = '0;
  logic [IDW-1:0] slot_sel_i = '0, dec_slot_i = '0;
  logic [XLEN-1:0] pc_i = '0, rs1_i = '0, imm_i_i = '0, imm_z_i = '0;
  logic [2:0] wr_en_o;
  logic rs1_used_o, illegal_o;
  logic [NSLOT-1:0][XLEN-1:0] start_o, end_o, cnt_o;

  logic [31:0] m_start [NSLOT];
  logic [31:0] m_end   [NSLOT];
  logic [31:0] m_cnt   [NSLOT];
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwloop_bank #(.NSLOT(NSLOT), .XLEN(XLEN), .IDW(IDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .funct3_i(funct3_i),
    .slot_sel_i(slot_sel_i), .pc_i(pc_i), .rs1_i(rs1_i), .imm_i_i(imm_i_i),
    .imm_z_i(imm_z_i), .dec_req_i(dec_req_i), .dec_slot_i(dec_slot_i),
    .stall_i(stall_i), .wr_en_o(wr_en_o), .rs1_used_o(rs1_used_o),
    .illegal_o(illegal_o), .start_o(start_o), .end_o(end_o), .cnt_o(cnt_o));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    for (int s = 0; s < NSLOT; s++) begin
      chk(tag, $sformatf("start[%0d]", s), start_o[s], m_start[s]);
      chk(tag, $sformatf("end[%0d]", s),   end_o[s],   m_end[s]);
      chk(tag, $sformatf("cnt[%0d]", s),   cnt_o[s],   m_cnt[s]);
    end
  endtask

  function automatic string tag_of(logic [2:0] f);
    case (f)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010, 3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model_step();
    logic wrote_cnt;
    wrote_cnt = 1'b0;
    if (op_valid_i && int'(slot_sel_i) < NSLOT) begin
      case (funct3_i)
        3'b000: m_start[slot_sel_i] = pc_i + imm_i_i;
        3'b001: m_end[slot_sel_i]   = pc_i + imm_i_i;
        3'b010: begin m_cnt[slot_sel_i] = rs1_i;   wrote_cnt = 1'b1; end
        3'b011: begin m_cnt[slot_sel_i] = imm_i_i; wrote_cnt = 1'b1; end
        3'b100: begin
          m_start[slot_sel_i] = pc_i + 32'd4;
          m_end[slot_sel_i]   = pc_i + imm_i_i;
          m_cnt[slot_sel_i]   = rs1_i;
          wrote_cnt = 1'b1;
        end
        3'b101: begin
          m_start[slot_sel_i] = pc_i + 32'd4;
          m_end[slot_sel_i]   = pc_i + {imm_z_i[30:0], 1'b0};
          m_cnt[slot_sel_i]   = imm_i_i;
          wrote_cnt = 1'b1;
        end
        default: ;
      endcase
    end
    if (dec_req_i && !stall_i && int'(dec_slot_i) < NSLOT
        && !(wrote_cnt && dec_slot_i == slot_sel_i) && m_cnt[dec_slot_i] != 0)
      m_cnt[dec_slot_i] = m_cnt[dec_slot_i] - 1;
  endtask

  task automatic run_cycle(string tag, logic v, logic [2:0] f, logic [1:0] sl,
                           logic [31:0] pc, logic [31:0] r1, logic [31:0] ii, logic [31:0] iz,
                           logic dq, logic [1:0] ds, logic st, logic [2:0] exp_wr);
    op_valid_i = v; funct3_i = f; slot_sel_i = sl; pc_i = pc; rs1_i = r1;
    imm_i_i = ii; imm_z_i = iz; dec_req_i = dq; dec_slot_i = ds; stall_i = st;
    #1;
    chk(tag, "wr_en", 32'(wr_en_o), 32'(exp_wr));
    chk(tag, "illegal", 32'(illegal_o), 32'(v && f[2] && f[1]));
    chk(tag, "rs1_used", 32'(rs1_used_o), 32'(v && (f == 3'b010 || f == 3'b100)));
    model_step();
    @(negedge clk);
    op_valid_i = 1'b0; dec_req_i = 1'b0; stall_i = 1'b0;
    #1;
    check_state(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) begin m_start[s] = 0; m_end[s] = 0; m_cnt[s] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check_state("R1");
    chk("R1", "wr_en idle", 32'(wr_en_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_cycle(tag_of(V_F3[i]), 1'b1, V_F3[i], V_SLOT[i], V_PC[i], V_RS1[i],
                V_IMMI[i], V_IMMZ[i], 1'b0, 2'd0, 1'b0, V_WR[i]);

    // R9: decrement slot 0 by one
    run_cycle("R9", 1'b0, 3'b000, 2'd0, 0, 0, 0, 0, 1'b1, 2'd0, 1'b0, 3'b000);
    chk("R9", "cnt0 after dec", cnt_o[0], 32'd8);
    // R10: stall blocks the decrement
    run_cycle("R10", 1'b0, 3'b000, 2'd0, 0, 0, 0, 0, 1'b1, 2'd0, 1'b1, 3'b000);
    chk("R10", "cnt0 under stall", cnt_o[0], 32'd8);
    // R11: write beats decrement on the same slot
    run_cycle("R11", 1'b1, 3'b011, 2'd0, 32'h500, 0, 32'h50, 0, 1'b1, 2'd0, 1'b0, 3'b100);
    chk("R11", "cnt0 write wins", cnt_o[0], 32'h50);
    // R11: write to slot 0 while slot 1 decrements
    run_cycle("R11", 1'b1, 3'b011, 2'd0, 32'h504, 0, 32'h60, 0, 1'b1, 2'd1, 1'b0, 3'b100);
    chk("R11", "cnt1 other slot dec", cnt_o[1], 32'h24);
    // R9: counter at zero holds
    run_cycle("R9", 1'b1, 3'b011, 2'd1, 32'h508, 0, 32'h0, 0, 1'b0, 2'd0, 1'b0, 3'b100);
    run_cycle("R9", 1'b0, 3'b000, 2'd0, 0, 0, 0, 0, 1'b1, 2'd1, 1'b0, 3'b000);
    chk("R9", "cnt1 zero hold", cnt_o[1], 32'h0);
    // R8: out-of-range slot index writes nothing
    run_cycle("R8", 1'b1, 3'b100, 2'd3, 32'h600, 32'h77, 32'h10, 0, 1'b0, 2'd0, 1'b0, 3'b111);
    run_cycle("R8", 1'b1, 3'b101, 2'd2, 32'h700, 0, 32'h33, 32'h8, 1'b0, 2'd0, 1'b0, 3'b111);
    // R7: op_valid low decodes nothing
    run_cycle("R7", 1'b0, 3'b100, 2'd0, 32'h800, 32'h55, 32'h4, 0, 1'b0, 2'd0, 1'b0, 3'b000);
    // R5: full setup on slot 0 with wrapping end address
    run_cycle("R5", 1'b1, 3'b100, 2'd0, 32'hFFFF_FFF0, 32'h3, 32'h20, 0, 1'b0, 2'd0, 1'b0, 3'b111);
    chk("R5", "end0 wrap", end_o[0], 32'h10);

    finish_run();
  end
endmodule